// File: doc/BRIEF.md
# Vector Element Fixed-Point ALU Lane

This block is one element lane of a vector integer unit. Each accepted transaction carries two SEW-bit operands, A and B, an operation code, a two-bit rounding mode, a mask bit and the element's current destination value. The lane computes one SEW-bit result and a flag that reports whether a saturating operation had to clamp. The operations are wrapping add and subtract, bitwise logic, saturating add and subtract (signed and unsigned), a rounding fractional signed multiply, plain and rounding shifts, and signed or unsigned min and max. The same rounding-increment logic serves the fractional multiply and the rounding shifts.

Transactions enter through a valid/ready handshake and leave through a second handshake from a single result register. A new element may enter in the same cycle that the previous result is taken. When the mask bit is low, the lane returns the old destination value unchanged and reports no saturation.

Top module: `vfx_lane`

## Requirements
- R1: Op 0 (A+B), op 1 (A−B) and op 10 (A shifted left) wrap modulo 2^SEW and leave satFlag low.
- R2: Op 2 gives A AND B, op 3 gives A OR B, op 4 gives A XOR B, with satFlag low.
- R3: Op 5 adds A and B as unsigned numbers and clamps to all ones if the sum overflows. Op 7 subtracts B from A as unsigned numbers and gives zero when A < B. satFlag is high exactly when a clamp happened.
- R4: Op 6 (A+B) and op 8 (A−B) work on signed numbers and clamp to the most positive or most negative SEW-bit value on overflow. satFlag is high exactly when a clamp happened.
- R5: Op 9 forms the 2·SEW-bit signed product A·B, shifts it right arithmetically by SEW−1, adds the rounding increment of the discarded bits and saturates to SEW bits. Most-negative times most-negative gives the most positive value with satFlag high.
- R6: For shift ops 10 through 14, the shift amount is the low log2(SEW) bits of B. Op 11 is a logical right shift. Op 12 is an arithmetic right shift that fills with A's sign bit. None of these ops sets satFlag.
- R7: Op 13 (logical) and op 14 (arithmetic) are right shifts that add a rounding increment. Let h be the highest discarded bit, s the OR of the lower discarded bits and k the lowest kept bit. rndMode 0 adds h. Mode 1 adds h·(s|k). Mode 2 adds 0. Mode 3 adds ¬k·(h|s). With a shift of zero the increment is 0.
- R8: Op 15 is the unsigned minimum, op 16 the signed minimum, op 17 the unsigned maximum and op 18 the signed maximum. The result is the chosen operand unchanged and satFlag is low.
- R9: A transaction accepted with maskBit low returns oldDest as the result, with satFlag low, whatever the op.
- R10: inReady equals (not outValid) or outReady. The result appears with outValid high one cycle after acceptance, and stays stable while outValid is high and outReady is low.
- R11: After reset, outValid, result and satFlag are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | An element is offered |
| inReady | output | 1 | The lane can take an element this cycle |
| opSel | input | 5 | Operation code (see requirements) |
| rndMode | input | 2 | Rounding mode for ops 9, 13 and 14 |
| maskBit | input | 1 | Element active; low passes oldDest through |
| opA | input | SEW | Operand A |
| opB | input | SEW | Operand B; its low bits give the shift amount |
| oldDest | input | SEW | Current destination value of the element |
| outValid | output | 1 | Result register holds a result |
| outReady | input | 1 | Consumer takes the result this cycle |
| result | output | SEW | Element result |
| satFlag | output | 1 | The saturating operation clamped |

## Verification
Every result of every operation is due exactly one rising edge after the edge at which the element is accepted. The bench drives an element at a falling edge, lets one rising edge accept it, and reads result, satFlag and outValid at the next falling edge. In the back-pressure case, the result must stay unchanged over several rising edges while outReady is low. A second element offered during that time must not be accepted until outReady rises. That element's result is then read at the falling edge after the edge that accepts it.

// File: rtl/vfx_pkg.sv
package vfx_pkg;

  typedef enum logic [4:0] {
    OP_ADD   = 5'd0,
    OP_SUB   = 5'd1,
    OP_AND   = 5'd2,
    OP_OR    = 5'd3,
    OP_XOR   = 5'd4,
    OP_SADDU = 5'd5,
    OP_SADD  = 5'd6,
    OP_SSUBU = 5'd7,
    OP_SSUB  = 5'd8,
    OP_FMUL  = 5'd9,
    OP_SLL   = 5'd10,
    OP_SRL   = 5'd11,
    OP_SRA   = 5'd12,
    OP_RSRL  = 5'd13,
    OP_RSRA  = 5'd14,
    OP_MINU  = 5'd15,
    OP_MIN   = 5'd16,
    OP_MAXU  = 5'd17,
    OP_MAX   = 5'd18
  } vfxOp_e;

  typedef enum logic [1:0] {
    RND_NEAR_UP   = 2'd0,
    RND_NEAR_EVEN = 2'd1,
    RND_DOWN      = 2'd2,
    RND_ODD       = 2'd3
  } vfxRnd_e;

  // control -> datapath strobes
  typedef struct packed {
    logic load;      // capture a new element this cycle
    logic passThru;  // element masked off: keep old destination
  } vfxStrobe_t;

endpackage

// File: rtl/vfx_ctrl.sv
module vfx_ctrl
  import vfx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       outReady,
  input  logic       maskBit,
  output logic       inReady,
  output logic       outValid,
  output vfxStrobe_t strobe
);

  always_comb begin
    inReady         = !outValid || outReady;
    strobe.load     = inValid && inReady;
    strobe.passThru = !maskBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            outValid <= 1'b0;
    else if (strobe.load) outValid <= 1'b1;
    else if (outReady)    outValid <= 1'b0;
  end

endmodule

// File: rtl/vfx_datapath.sv
module vfx_datapath
  import vfx_pkg::*;
#(
  parameter int SEW = 32
) (
  input  logic           clk,
  input  logic           rstN,
  input  vfxStrobe_t     strobe,
  input  logic [4:0]     opSel,
  input  logic [1:0]     rndMode,
  input  logic [SEW-1:0] opA,
  input  logic [SEW-1:0] opB,
  input  logic [SEW-1:0] oldDest,
  output logic [SEW-1:0] result,
  output logic           satFlag
);

  localparam int SH_W = $clog2(SEW);
  localparam int WIDE = 2 * SEW;
  localparam logic [SEW-1:0] MAX_POS = {1'b0, {(SEW-1){1'b1}}};
  localparam logic [SEW-1:0] MIN_NEG = {1'b1, {(SEW-1){1'b0}}};

  // increment for dropping the low d bits of v
  function automatic logic roundInc(input logic [WIDE-1:0] v, input int unsigned d,
                                    input logic [1:0] mode);
    logic half, rest, keep;
    logic [WIDE-1:0] lowMask;
    if (d == 0) return 1'b0;
    half    = v[d-1];
    keep    = v[d];
    lowMask = ~({WIDE{1'b1}} << (d - 1));
    rest    = |(v & lowMask);
    case (mode)
      2'd0:    return half;
      2'd1:    return half & (rest | keep);
      2'd2:    return 1'b0;
      default: return !keep & (half | rest);
    endcase
  endfunction

  // clamp a signed SEW+1 value into SEW bits
  function automatic logic [SEW:0] clampSigned(input logic [SEW:0] v);
    if (v[SEW] != v[SEW-1]) return {1'b1, (v[SEW] ? MIN_NEG : MAX_POS)};
    return {1'b0, v[SEW-1:0]};
  endfunction

  vfxOp_e           opE;
  logic [SH_W-1:0]  amt;
  logic [WIDE-1:0]  aExt, bExt, prod, mulWide;
  logic signed [WIDE-1:0] prodS, prodSh, sraWide;
  logic [SEW:0]     sumU, sumS, difS, clampOut;
  logic [SEW-1:0]   srlRaw;
  logic             aLtBu, aLtBs;
  logic [SEW-1:0]   nextRes;
  logic             nextSat;

  always_comb begin
    opE     = vfxOp_e'(opSel);
    amt     = opB[SH_W-1:0];
    aExt    = {{SEW{opA[SEW-1]}}, opA};
    bExt    = {{SEW{opB[SEW-1]}}, opB};
    sumU    = {1'b0, opA} + {1'b0, opB};
    sumS    = {opA[SEW-1], opA} + {opB[SEW-1], opB};
    difS    = {opA[SEW-1], opA} - {opB[SEW-1], opB};
    prod    = aExt * bExt;
    prodS   = prod;
    prodSh  = prodS >>> (SEW - 1);
    mulWide = prodSh + {{(WIDE-1){1'b0}}, roundInc(prod, SEW - 1, rndMode)};
    sraWide = $signed(aExt) >>> amt;
    srlRaw  = opA >> amt;
    aLtBu   = opA < opB;
    aLtBs   = $signed(opA) < $signed(opB);
    clampOut = '0;
    nextRes = '0;
    nextSat = 1'b0;
    case (opE)
      OP_ADD:   nextRes = opA + opB;
      OP_SUB:   nextRes = opA - opB;
      OP_AND:   nextRes = opA & opB;
      OP_OR:    nextRes = opA | opB;
      OP_XOR:   nextRes = opA ^ opB;
      OP_SADDU: begin
        nextSat = sumU[SEW];
        nextRes = sumU[SEW] ? {SEW{1'b1}} : sumU[SEW-1:0];
      end
      OP_SSUBU: begin
        nextSat = aLtBu;
        nextRes = aLtBu ? '0 : opA - opB;
      end
      OP_SADD: begin
        clampOut = clampSigned(sumS);
        {nextSat, nextRes} = clampOut;
      end
      OP_SSUB: begin
        clampOut = clampSigned(difS);
        {nextSat, nextRes} = clampOut;
      end
      OP_FMUL: begin
        clampOut = clampSigned(mulWide[SEW:0]);
        {nextSat, nextRes} = clampOut;
      end
      OP_SLL:   nextRes = opA << amt;
      OP_SRL:   nextRes = srlRaw;
      OP_SRA:   nextRes = sraWide[SEW-1:0];
      OP_RSRL:  nextRes = srlRaw + {{(SEW-1){1'b0}},
                                    roundInc({{SEW{1'b0}}, opA}, amt, rndMode)};
      OP_RSRA:  nextRes = sraWide[SEW-1:0] + {{(SEW-1){1'b0}},
                                              roundInc(aExt, amt, rndMode)};
      OP_MINU:  nextRes = aLtBu ? opA : opB;
      OP_MIN:   nextRes = aLtBs ? opA : opB;
      OP_MAXU:  nextRes = aLtBu ? opB : opA;
      OP_MAX:   nextRes = aLtBs ? opB : opA;
      default:  nextRes = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result  <= '0;
      satFlag <= 1'b0;
    end else if (strobe.load) begin
      if (strobe.passThru) begin
        result  <= oldDest;
        satFlag <= 1'b0;
      end else begin
        result  <= nextRes;
        satFlag <= nextSat;
      end
    end
  end

endmodule

// File: rtl/vfx_lane.sv
module vfx_lane
  import vfx_pkg::*;
#(
  parameter int SEW = 32
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           inValid,
  output logic           inReady,
  input  logic [4:0]     opSel,
  input  logic [1:0]     rndMode,
  input  logic           maskBit,
  input  logic [SEW-1:0] opA,
  input  logic [SEW-1:0] opB,
  input  logic [SEW-1:0] oldDest,
  output logic           outValid,
  input  logic           outReady,
  output logic [SEW-1:0] result,
  output logic           satFlag
);

  vfxStrobe_t strobe;

  vfx_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .outReady (outReady),
    .maskBit  (maskBit),
    .inReady  (inReady),
    .outValid (outValid),
    .strobe   (strobe)
  );

  vfx_datapath #(.SEW(SEW)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .opSel   (opSel),
    .rndMode (rndMode),
    .opA     (opA),
    .opB     (opB),
    .oldDest (oldDest),
    .result  (result),
    .satFlag (satFlag)
  );

endmodule

// File: rtl/vfx_lane_chk.sv
module vfx_lane_chk #(
  parameter int SEW = 32
) (
  input logic           clk,
  input logic           rstN,
  input logic           inValid,
  input logic           inReady,
  input logic [4:0]     opSel,
  input logic           maskBit,
  input logic [SEW-1:0] opA,
  input logic [SEW-1:0] opB,
  input logic [SEW-1:0] oldDest,
  input logic           outValid,
  input logic           outReady,
  input logic [SEW-1:0] result,
  input logic           satFlag
);

  logic accept;
  assign accept = inValid && inReady;

  // R10: a stalled result holds
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(result) && $stable(satFlag));

  // R10: no acceptance while a stalled result is held
  a_r10_block: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |-> !inReady);

  // R10: result valid one cycle after acceptance
  a_r10_latency: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> outValid);

  // R9: masked-off element passes old destination
  a_r9_pass: assert property (@(posedge clk) disable iff (!rstN)
    accept && !maskBit |=> result == $past(oldDest) && !satFlag);

  // R1: wrapping add/sub/shift-left never flag
  a_r1_no_sat: assert property (@(posedge clk) disable iff (!rstN)
    accept && (opSel == 5'd0 || opSel == 5'd1 || opSel == 5'd10) |=> !satFlag);

  // R8: min/max return one of the operands
  a_r8_pick: assert property (@(posedge clk) disable iff (!rstN)
    accept && maskBit && opSel >= 5'd15 && opSel <= 5'd18
    |=> (result == $past(opA) || result == $past(opB)) && !satFlag);

  // R3: unsigned saturating subtract clamps to zero
  a_r3_floor: assert property (@(posedge clk) disable iff (!rstN)
    accept && maskBit && opSel == 5'd7 && opA < opB |=> result == '0 && satFlag);

endmodule

bind vfx_lane vfx_lane_chk #(.SEW(SEW)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inReady  (inReady),
  .opSel    (opSel),
  .maskBit  (maskBit),
  .opA      (opA),
  .opB      (opB),
  .oldDest  (oldDest),
  .outValid (outValid),
  .outReady (outReady),
  .result   (result),
  .satFlag  (satFlag)
);

// File: tb/vfx_lane_test.sv
`timescale 1ns/1ps
module vfx_lane_test;

  localparam int SEW = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic       inReady;
  logic [4:0] opSel = '0;
  logic [1:0] rndMode = '0;
  logic       maskBit = 1'b1;
  logic [7:0] opA = '0, opB = '0, oldDest = '0;
  logic       outValid;
  logic       outReady = 1'b1;
  logic [7:0] result;
  logic       satFlag;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  vfx_lane #(.SEW(SEW)) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .opSel(opSel), .rndMode(rndMode), .maskBit(maskBit),
    .opA(opA), .opB(opB), .oldDest(oldDest),
    .outValid(outValid), .outReady(outReady),
    .result(result), .satFlag(satFlag)
  );

  function automatic string reqOf(input int op);
    case (op)
      0, 1, 10:       return "R1";
      2, 3, 4:        return "R2";
      5, 7:           return "R3";
      6, 8:           return "R4";
      9:              return "R5";
      11, 12:         return "R6";
      13, 14:         return "R7";
      default:        return "R8";
    endcase
  endfunction

  function automatic int sx(input int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  // R7 increment, integer form
  function automatic int rinc(input int v, input int d, input int mode);
    int h, s, k;
    if (d == 0) return 0;
    h = (v >> (d - 1)) & 1;
    s = (d > 1) ? (((v & ((1 << (d - 1)) - 1)) != 0) ? 1 : 0) : 0;
    k = (v >> d) & 1;
    case (mode)
      0: return h;
      1: return h & (s | k);
      2: return 0;
      default: return (1 - k) & (h | s);
    endcase
  endfunction

  function automatic int clampS(input int v, output int s);
    s = 0;
    if (v > 127)  begin s = 1; return 127;  end
    if (v < -128) begin s = 1; return -128; end
    return v;
  endfunction

  task automatic refModel(input int op, input int mode, input int a, input int b,
                          output int r, output int s);
    int sa, sb, amt, p, q;
    sa = sx(a); sb = sx(b); amt = b & 7; s = 0;
    case (op)
      0:  r = a + b;
      1:  r = a - b;
      2:  r = a & b;
      3:  r = a | b;
      4:  r = a ^ b;
      5:  begin r = a + b; if (r > 255) begin r = 255; s = 1; end end
      6:  r = clampS(sa + sb, s);
      7:  begin if (a < b) begin r = 0; s = 1; end else r = a - b; end
      8:  r = clampS(sa - sb, s);
      9:  begin p = sa * sb; q = (p >>> 7) + rinc(p, 7, mode); r = clampS(q, s); end
      10: r = a << amt;
      11: r = a >> amt;
      12: r = sa >>> amt;
      13: r = (a >> amt) + rinc(a, amt, mode);
      14: r = (sa >>> amt) + rinc(sa, amt, mode);
      15: r = (a < b) ? a : b;
      16: r = (sa < sb) ? a : b;
      17: r = (a < b) ? b : a;
      default: r = (sa < sb) ? b : a;
    endcase
    r = r & 255;
  endtask

  task automatic check(input string req, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  // drive at falling edge, accepted at next rising edge, sampled at following falling edge
  task automatic runOp(input int op, input int mode, input int msk,
                       input int a, input int b, input int old);
    int er, es;
    @(negedge clk);
    opSel = 5'(op); rndMode = 2'(mode); maskBit = msk[0];
    opA = 8'(a); opB = 8'(b); oldDest = 8'(old);
    inValid = 1'b1; outReady = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    if (msk != 0) refModel(op, mode, a, b, er, es);
    else begin er = old & 255; es = 0; end
    check(msk != 0 ? reqOf(op) : "R9", "result", int'(result), er);
    check(msk != 0 ? reqOf(op) : "R9", "satFlag", int'(satFlag), es);
    check("R10", "outValid", int'(outValid), 1);
  endtask

  initial begin
    #(64'd20 * 64'd150000);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd2417);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R11 reset state
    check("R11", "outValid", int'(outValid), 0);
    check("R11", "result", int'(result), 0);
    check("R11", "satFlag", int'(satFlag), 0);

    // directed corners
    runOp(0, 0, 1, 200, 100, 0);      // R1 wrap
    runOp(10, 0, 1, 8'hC3, 8'h0A, 0); // R1 shift left, amt 2
    runOp(4, 0, 1, 8'hF0, 8'h3C, 0);  // R2
    runOp(5, 0, 1, 200, 100, 0);      // R3 clamp high
    runOp(7, 0, 1, 5, 9, 0);          // R3 floor
    runOp(6, 0, 1, 100, 100, 0);      // R4 positive clamp
    runOp(6, 0, 1, 8'h9C, 8'h9C, 0);  // R4 negative clamp
    runOp(8, 0, 1, 8'h80, 1, 0);      // R4
    runOp(9, 0, 1, 8'h80, 8'h80, 0);  // R5 min*min
    runOp(9, 0, 1, 8'h40, 8'h40, 0);  // R5
    runOp(9, 1, 1, 8'hC5, 8'h33, 0);  // R5 rounding
    runOp(12, 0, 1, 8'h80, 8'h0B, 0); // R6 amt from low 3 bits
    runOp(11, 0, 1, 8'h80, 8'hF9, 0); // R6
    for (int m = 0; m < 4; m++) runOp(13, m, 1, 8'h0A, 2, 0); // R7 each mode
    for (int m = 0; m < 4; m++) runOp(14, m, 1, 8'hF5, 3, 0); // R7 arithmetic
    runOp(16, 0, 1, 8'h80, 1, 0);     // R8
    runOp(15, 0, 1, 8'h80, 1, 0);     // R8
    runOp(5, 0, 0, 200, 100, 8'h5A);  // R9 masked

    // R10 back-pressure
    @(negedge clk);
    opSel = 5'd0; maskBit = 1'b1; opA = 8'd1; opB = 8'd2;
    inValid = 1'b1; outReady = 1'b0;
    @(negedge clk);
    opA = 8'd5; opB = 8'd5;
    check("R10", "inReady stalled", int'(inReady), 0);
    check("R10", "first result", int'(result), 3);
    repeat (2) @(negedge clk);
    check("R10", "held result", int'(result), 3);
    check("R10", "held valid", int'(outValid), 1);
    outReady = 1'b1;
    #1;
    check("R10", "inReady released", int'(inReady), 1);
    @(negedge clk);
    inValid = 1'b0;
    check("R10", "second result", int'(result), 10);
    @(negedge clk);
    check("R10", "drained", int'(outValid), 0);

    // constrained random
    for (int i = 0; i < 600; i++) begin
      int op, mode, msk, a, b;
      op = int'($urandom_range(0, 18));
      mode = int'($urandom_range(0, 3));
      msk = ($urandom_range(0, 7) != 0) ? 1 : 0;
      a = int'($urandom_range(0, 255));
      b = int'($urandom_range(0, 255));
      runOp(op, mode, msk, a, b, int'($urandom_range(0, 255)));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule